// File: doc/BRIEF.md
# Dual-Protocol Nibble Host Register Interface

This block puts four 4-bit registers behind a small host bus. Two of the registers are write-only: a transmit code and a control word. The other two are read-only: a receive code and a status word. A static select pin sets how the same bus pins are read.

- In the separate-strobe protocol, a latch-enable pin captures a 2-bit address from the data lines on its falling edge. A write pulse and a read pulse, each active low and qualified by an active-low chip select, then move the data.
- In the clocked-strobe protocol, the latch-enable pin becomes an address level and the write pin becomes a read/write level. All transfers are timed by one strobe.

All host pins are asynchronous to the block clock. They pass through two-flop synchronizers before any edge is detected.

The status word reports three detector flags and a sticky change flag. The flags come from tone-detection engines that sit outside the block. The block masks the flags with a detector-enable control bit and with each other. The change flag is set on a new detection. It is cleared either by a completed status read or when every detected signal has gone away. A power-down input clears the writable registers and forces the status word to its idle value.

Top module: `nib_host_if`

## Requirements
- R1: With `bus_sel_i`=1, a falling edge on `bus_adr_i` latches the address from D1:D0. A rising edge on `bus_wr_i` while `bus_cs_ni`=0 then writes D3:D0. Address 00 writes the transmit code (`tx_code_o`) and address 10 writes the control word.
- R2: With `bus_sel_i`=1, `bus_oe_o` is 1 only while `bus_stb_i` and `bus_cs_ni` are both 0. In that window, address 01 returns `rx_code_i` and address 11 returns the status word.
- R3: With `bus_sel_i`=0, a falling edge on `bus_stb_i` with `bus_cs_ni`=0 and `bus_wr_i`=0 writes D3:D0. The target is the control word when `bus_adr_i`=1 and the transmit code when `bus_adr_i`=0.
- R4: With `bus_sel_i`=0, a rising edge on `bus_stb_i` with `bus_cs_ni`=0 and `bus_wr_i`=1 captures `bus_adr_i` (1 = status, 0 = receive code). The bus is then driven while `bus_stb_i` is high and released once it falls.
- R5: While `bus_cs_ni`=1, no register is written and `bus_oe_o` stays 0.
- R6: Control bit 0 drives `tone_tx_en_o`, bit 1 drives `det_en_o`, bit 2 drives `fast_det_o` and bit 3 drives `prog_tx_en_o`.
- R7: Status bit 0 is the change flag, bit 1 the progress-tone flag and bit 2 the fax flag. Bit 3 is 0 while `dtmf_vld_i` is 1 and 1 otherwise.
- R8: While `det_en_o`=0, the progress-tone and fax status bits and `prog_det_o`/`fax_det_o` are 0.
- R9: The fax bit and `fax_det_o` are 0 while the progress-tone bit is 1.
- R10: The change flag sets when `dtmf_vld_i` rises or when the gated fax or progress bit rises. It clears at the end of a status read.
- R11: The change flag clears without a read once DTMF, fax and progress are all inactive.
- R12: While `pwr_dn_i`=1, the control word and transmit code read as 0, writes are ignored and the status word reads 4'b1000.
- R13: After reset, all register outputs are 0 and `bus_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Protocol select: 1 separate strobes, 0 clocked strobe |
| pwr_dn_i | input | 1 | Power-down, clears registers |
| bus_cs_ni | input | 1 | Chip select, active low |
| bus_stb_i | input | 1 | Read strobe (active low) or transfer clock |
| bus_adr_i | input | 1 | Address latch enable or address level |
| bus_wr_i | input | 1 | Write strobe (active low) or read/write level |
| bus_d_i | input | 4 | Data / address from host |
| bus_d_o | output | 4 | Read data to host |
| bus_oe_o | output | 1 | Drive enable for bus_d_o |
| rx_code_i | input | 4 | Received digit code |
| dtmf_vld_i | input | 1 | Valid DTMF pair present |
| prog_det_i | input | 1 | Raw progress-tone detection |
| fax_det_i | input | 1 | Raw fax-tone detection |
| tx_code_o | output | 4 | Transmit digit code |
| tone_tx_en_o | output | 1 | DTMF transmit enable |
| det_en_o | output | 1 | Detector output enable |
| fast_det_o | output | 1 | Fast detection mode |
| prog_tx_en_o | output | 1 | Progress-tone transmit enable |
| prog_det_o | output | 1 | Gated progress-tone flag |
| fax_det_o | output | 1 | Gated fax flag |

## Verification
The bench writes and reads every register through both protocols, alternating between them. A decoder that mixed up the address-level meaning between the two protocols would write the wrong register or return the wrong word. In the clocked protocol the bench checks that the bus stops being driven once the strobe falls; a design that held its read state would keep driving the bus. The bench also:
- drives the fax and progress flags together, which exposes missing cross-masking;
- lets the sources vanish without a read, which exposes a change flag that waits forever for the host;
- applies power-down with detectors active, which exposes a status word still reporting detections.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    A_TX   = 2'b00,
    A_RX   = 2'b01,
    A_CTRL = 2'b10,
    A_STAT = 2'b11
  } reg_addr_e;

  typedef struct packed {
    logic prog_tx;
    logic fast;
    logic det_en;
    logic tone_en;
  } ctrl_t;
endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= async_i;
      else             stg[s] <= stg[(s > 0) ? s-1 : 0];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/nib_bus_dec.sv
module nib_bus_dec
  import nib_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sep_i,
  input  logic             stb_s_i,
  input  logic             cs_ns_i,
  input  logic             adr_s_i,
  input  logic             wr_s_i,
  input  logic [NIB_W-1:0] d_s_i,
  output logic             wr_stb_o,
  output reg_addr_e        wr_addr_o,
  output reg_addr_e        rd_addr_o,
  output logic             rd_end_o,
  output logic             oe_o
);
  logic      stb_p, adr_p, wr_p, rd_act;
  reg_addr_e addr_q;

  wire stb_rise = stb_s_i & ~stb_p;
  wire stb_fall = ~stb_s_i & stb_p;
  wire adr_fall = ~adr_s_i & adr_p;
  wire wr_rise  = wr_s_i & ~wr_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_p  <= 1'b0;
      adr_p  <= 1'b0;
      wr_p   <= 1'b1;
      addr_q <= A_TX;
      rd_act <= 1'b0;
    end else begin
      stb_p <= stb_s_i;
      adr_p <= adr_s_i;
      wr_p  <= wr_s_i;
      if (sep_i) begin
        rd_act <= 1'b0;
        if (adr_fall) addr_q <= reg_addr_e'(d_s_i[1:0]);
      end else if (stb_rise && !cs_ns_i && wr_s_i) begin
        addr_q <= reg_addr_e'({adr_s_i, 1'b1});
        rd_act <= 1'b1;
      end else if (stb_fall) begin
        rd_act <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_addr_o = addr_q;
    if (sep_i) begin
      wr_stb_o  = wr_rise & ~cs_ns_i;
      wr_addr_o = addr_q;
      oe_o      = ~stb_s_i & ~cs_ns_i;
      rd_end_o  = stb_rise & ~cs_ns_i;
    end else begin
      wr_stb_o  = stb_fall & ~cs_ns_i & ~wr_s_i;
      wr_addr_o = reg_addr_e'({adr_s_i, 1'b0});
      oe_o      = rd_act & stb_s_i & ~cs_ns_i;
      rd_end_o  = stb_fall & rd_act;
    end
  end

  AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> !cs_ns_i); // R5
  AST_CK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sep_i && stb_fall) |=> !oe_o); // R4
endmodule

// File: rtl/nib_regs.sv
module nib_regs
  import nib_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_dn_i,
  input  logic             wr_stb_i,
  input  reg_addr_e        wr_addr_i,
  input  logic [NIB_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o,
  output logic [NIB_W-1:0] tx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      tx_o   <= '0;
    end else if (pwr_dn_i) begin
      ctrl_o <= '0;
      tx_o   <= '0;
    end else if (wr_stb_i) begin
      if (wr_addr_i == A_CTRL) ctrl_o <= ctrl_t'(wr_data_i);
      if (wr_addr_i == A_TX)   tx_o   <= wr_data_i;
    end
  end

  AST_PD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwr_dn_i) |-> (ctrl_o == '0 && tx_o == '0)); // R12
endmodule

// File: rtl/nib_status.sv
module nib_status
  import nib_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_dn_i,
  input  logic             det_en_i,
  input  logic             dtmf_i,
  input  logic             prog_i,
  input  logic             fax_i,
  input  logic             rd_clr_i,
  output logic [NIB_W-1:0] stat_o,
  output logic             prog_o,
  output logic             fax_o
);
  logic dtmf_q, prog_q, fax_q, flag_q;
  logic dtmf_n, prog_n, fax_n, set_n, any_n;

  always_comb begin
    dtmf_n = ~pwr_dn_i & dtmf_i;
    prog_n = ~pwr_dn_i & det_en_i & prog_i;
    fax_n  = ~pwr_dn_i & det_en_i & fax_i & ~prog_n;
    set_n  = (dtmf_n & ~dtmf_q) | (prog_n & ~prog_q) | (fax_n & ~fax_q);
    any_n  = dtmf_n | prog_n | fax_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtmf_q <= 1'b0;
      prog_q <= 1'b0;
      fax_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      dtmf_q <= dtmf_n;
      prog_q <= prog_n;
      fax_q  <= fax_n;
      flag_q <= set_n | (flag_q & any_n & ~rd_clr_i);
    end
  end

  assign stat_o = {~dtmf_q, fax_q, prog_q, flag_q};
  assign prog_o = prog_q;
  assign fax_o  = fax_q;

  AST_FAX_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fax_q |-> !prog_q); // R9
  AST_DET_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(det_en_i) |-> (!prog_q && !fax_q)); // R8
  AST_FLAG_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> (dtmf_q || prog_q || fax_q)); // R11
  AST_PD_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> (stat_o == 4'b1000)); // R12
endmodule

// File: rtl/nib_host_if.sv
module nib_host_if
  import nib_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             pwr_dn_i,
  input  logic             bus_cs_ni,
  input  logic             bus_stb_i,
  input  logic             bus_adr_i,
  input  logic             bus_wr_i,
  input  logic [NIB_W-1:0] bus_d_i,
  output logic [NIB_W-1:0] bus_d_o,
  output logic             bus_oe_o,
  input  logic [NIB_W-1:0] rx_code_i,
  input  logic             dtmf_vld_i,
  input  logic             prog_det_i,
  input  logic             fax_det_i,
  output logic [NIB_W-1:0] tx_code_o,
  output logic             tone_tx_en_o,
  output logic             det_en_o,
  output logic             fast_det_o,
  output logic             prog_tx_en_o,
  output logic             prog_det_o,
  output logic             fax_det_o
);
  localparam int SYNC_W = NIB_W + 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b0101, {NIB_W{1'b0}}};

  logic [SYNC_W-1:0] sync_s;
  logic [NIB_W-1:0]  d_s, stat;
  logic              stb_s, cs_s, adr_s, wr_s;
  logic              wr_stb, rd_end;
  reg_addr_e         wr_addr, rd_addr;
  ctrl_t             ctrl;

  nib_sync #(.W(SYNC_W), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni,
    .async_i({bus_stb_i, bus_cs_ni, bus_adr_i, bus_wr_i, bus_d_i}),
    .sync_o (sync_s)
  );
  assign {stb_s, cs_s, adr_s, wr_s, d_s} = sync_s;

  nib_bus_dec u_dec (
    .clk_i, .rst_ni,
    .sep_i    (bus_sel_i),
    .stb_s_i  (stb_s),
    .cs_ns_i  (cs_s),
    .adr_s_i  (adr_s),
    .wr_s_i   (wr_s),
    .d_s_i    (d_s),
    .wr_stb_o (wr_stb),
    .wr_addr_o(wr_addr),
    .rd_addr_o(rd_addr),
    .rd_end_o (rd_end),
    .oe_o     (bus_oe_o)
  );

  nib_regs u_regs (
    .clk_i, .rst_ni,
    .pwr_dn_i,
    .wr_stb_i (wr_stb),
    .wr_addr_i(wr_addr),
    .wr_data_i(d_s),
    .ctrl_o   (ctrl),
    .tx_o     (tx_code_o)
  );

  nib_status u_stat (
    .clk_i, .rst_ni,
    .pwr_dn_i,
    .det_en_i(ctrl.det_en),
    .dtmf_i  (dtmf_vld_i),
    .prog_i  (prog_det_i),
    .fax_i   (fax_det_i),
    .rd_clr_i(rd_end && rd_addr == A_STAT),
    .stat_o  (stat),
    .prog_o  (prog_det_o),
    .fax_o   (fax_det_o)
  );

  always_comb begin
    unique case (rd_addr)
      A_RX:    bus_d_o = rx_code_i;
      A_STAT:  bus_d_o = stat;
      default: bus_d_o = '0;
    endcase
  end

  assign tone_tx_en_o = ctrl.tone_en;
  assign det_en_o     = ctrl.det_en;
  assign fast_det_o   = ctrl.fast;
  assign prog_tx_en_o = ctrl.prog_tx;
endmodule

// File: tb/tb_nib_host_if.sv
module tb_nib_host_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b1, pd = 1'b0, cs_n = 1'b1, stb = 1'b1, adr = 1'b0, wr = 1'b1;
  logic [3:0] d = '0, rx = 4'b1101;
  logic       dtmf = 1'b0, prog = 1'b0, fax = 1'b0;
  logic [3:0] d_o, tx_o;
  logic       oe_o, tone_o, det_o, fast_o, ptx_o, pdet_o, fdet_o;
  int         n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  nib_host_if dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .pwr_dn_i(pd),
    .bus_cs_ni(cs_n), .bus_stb_i(stb), .bus_adr_i(adr), .bus_wr_i(wr),
    .bus_d_i(d), .bus_d_o(d_o), .bus_oe_o(oe_o), .rx_code_i(rx),
    .dtmf_vld_i(dtmf), .prog_det_i(prog), .fax_det_i(fax),
    .tx_code_o(tx_o), .tone_tx_en_o(tone_o), .det_en_o(det_o),
    .fast_det_o(fast_o), .prog_tx_en_o(ptx_o), .prog_det_o(pdet_o),
    .fax_det_o(fdet_o)
  );

  // {sel, target ctrl, data}
  localparam logic [5:0] VEC [8] = '{
    6'b1_1_0101, 6'b1_0_1010, 6'b0_1_1010, 6'b0_0_0110,
    6'b1_1_1111, 6'b0_0_1001, 6'b0_1_0000, 6'b1_0_0011
  };

  task automatic step();
    repeat (5) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ctrl_pins();
    return {ptx_o, fast_o, det_o, tone_o};
  endfunction

  task automatic set_mode(input logic m);
    cs_n = 1'b1; sel = m; stb = m; wr = 1'b1; adr = 1'b0; step();
  endtask

  task automatic ss_write(input logic [1:0] a, input logic [3:0] v, input logic cs_low);
    d = {2'b00, a}; adr = 1'b1; step(); adr = 1'b0; step();
    d = v; cs_n = ~cs_low; step(); wr = 1'b0; step(); wr = 1'b1; step();
    cs_n = 1'b1; step();
  endtask

  task automatic ss_read(input logic [1:0] a, output logic [3:0] v, output logic oe);
    d = {2'b00, a}; adr = 1'b1; step(); adr = 1'b0; step();
    d = '0; cs_n = 1'b0; step(); stb = 1'b0; step();
    v = d_o; oe = oe_o; stb = 1'b1; step(); cs_n = 1'b1; step();
  endtask

  task automatic ck_write(input logic a, input logic [3:0] v);
    cs_n = 1'b0; wr = 1'b0; adr = a; d = v; step();
    stb = 1'b1; step(); stb = 1'b0; step(); cs_n = 1'b1; wr = 1'b1; step();
  endtask

  task automatic ck_read(input logic a, output logic [3:0] v, output logic oe_hi,
                         output logic oe_lo);
    cs_n = 1'b0; wr = 1'b1; adr = a; step();
    stb = 1'b1; step(); v = d_o; oe_hi = oe_o;
    stb = 1'b0; step(); oe_lo = oe_o; cs_n = 1'b1; step();
  endtask

  task automatic wr_reg(input logic is_ctrl, input logic [3:0] v);
    if (sel) ss_write({is_ctrl, 1'b0}, v, 1'b1);
    else     ck_write(is_ctrl, v);
  endtask

  task automatic rd_stat(output logic [3:0] v);
    logic o1, o2;
    if (sel) ss_read(2'b11, v, o1);
    else     ck_read(1'b1, v, o1, o2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [3:0] v;
    logic       oh, ol;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R13 reset state
    check("R13 ctrl", ctrl_pins(), 4'b0000);
    check("R13 tx", tx_o, 4'b0000);
    check("R13 oe/det", {oe_o, pdet_o, fdet_o, 1'b0}, 4'b0000);

    // R1 R3 R6 write table across both protocols
    for (int i = 0; i < 8; i++) begin
      if (sel != VEC[i][5]) set_mode(VEC[i][5]);
      wr_reg(VEC[i][4], VEC[i][3:0]);
      if (VEC[i][4]) check(VEC[i][5] ? "R1 R6 ctrl" : "R3 R6 ctrl", ctrl_pins(), VEC[i][3:0]);
      else           check(VEC[i][5] ? "R1 tx" : "R3 tx", tx_o, VEC[i][3:0]);
    end

    // R2 separate-strobe read of receive code
    set_mode(1'b1);
    ss_read(2'b01, v, oh);
    check("R2 rx data", v, 4'b1101);
    check("R2 oe during read", {3'b0, oh}, 4'b0001);
    check("R2 oe after read", {3'b0, oe_o}, 4'b0000);

    // R4 clocked read of receive code, release after strobe falls
    set_mode(1'b0);
    rx = 4'b0110;
    ck_read(1'b0, v, oh, ol);
    check("R4 rx data", v, 4'b0110);
    check("R4 oe strobe high", {3'b0, oh}, 4'b0001);
    check("R4 oe strobe low", {3'b0, ol}, 4'b0000);

    // R5 chip select high: no drive, no write
    set_mode(1'b1);
    ss_write(2'b00, 4'b0101, 1'b1);
    ss_write(2'b00, 4'b1110, 1'b0);
    check("R5 write blocked", tx_o, 4'b0101);
    stb = 1'b0; step();
    check("R5 no drive", {3'b0, oe_o}, 4'b0000);
    stb = 1'b1; step();

    // R7 R8 R9 R10 R11 status behaviour
    wr_reg(1'b1, 4'b0010);
    rd_stat(v);
    check("R7 idle status", v, 4'b1000);
    prog = 1'b1; step();
    check("R10 prog pin", {3'b0, pdet_o}, 4'b0001);
    rd_stat(v);
    check("R7 R10 prog flag", v, 4'b1011);
    rd_stat(v);
    check("R10 cleared by read", v, 4'b1010);
    fax = 1'b1; step();
    check("R9 fax masked pin", {3'b0, fdet_o}, 4'b0000);
    set_mode(1'b0);
    rd_stat(v);
    check("R9 fax masked", v, 4'b1010);
    prog = 1'b0; step();
    rd_stat(v);
    check("R10 fax rise", v, 4'b1101);
    fax = 1'b0; step();
    rd_stat(v);
    check("R11 auto clear", v, 4'b1000);
    fax = 1'b1; step(); fax = 1'b0; step();
    rd_stat(v);
    check("R11 clear no read", v, 4'b1000);
    prog = 1'b1;
    wr_reg(1'b1, 4'b0000);
    check("R8 prog gated pin", {3'b0, pdet_o}, 4'b0000);
    rd_stat(v);
    check("R8 prog gated", v, 4'b1000);

    // R12 power-down
    wr_reg(1'b1, 4'b1111);
    wr_reg(1'b0, 4'b0111);
    dtmf = 1'b1; pd = 1'b1; step();
    check("R12 ctrl cleared", ctrl_pins(), 4'b0000);
    check("R12 tx cleared", tx_o, 4'b0000);
    wr_reg(1'b0, 4'b1001);
    check("R12 write ignored", tx_o, 4'b0000);
    rd_stat(v);
    check("R12 status idle", v, 4'b1000);
    pd = 1'b0; step();
    rd_stat(v);
    check("R7 R10 dtmf rise", v, 4'b0001);
    rd_stat(v);
    check("R10 dtmf read clear", v, 4'b0000);
    dtmf = 1'b0; prog = 1'b0; step();
    rd_stat(v);
    check("R7 dtmf gone", v, 4'b1000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule